// File: doc/BRIEF.md
# Fetch Thread Selector for a Multithreaded Core

This block decides, every cycle, which hardware threads of a simultaneously multithreaded core are allowed to fetch, and how many instructions each may bring in. For every thread it keeps three live counters: instructions sitting between decode and issue, branches not yet resolved, and data-cache misses still outstanding. A two-bit policy input chooses how those counters are used to rank the threads. The ranking can be a plain rotation, or it can favour the thread with the smallest occupancy, the fewest unresolved branches or the fewest pending misses.

Threads that are not ready, are stalled on an instruction-cache miss, or have an empty fetch block are removed before ranking. Equal ranks are settled by a rotating pointer, which moves to one past the last thread granted. Up to two grants leave per cycle. A shape input selects one of three grant shapes:
- a single thread fetches up to the full fetch width;
- two threads each fetch up to half the width;
- two threads share the full width, with the first-ranked thread served first and the second filling the slots that are left.

The grant outputs are combinational from the current counters and the present inputs. The counters and the pointer update on the rising clock edge.

Top module: `fetch_selector`

## Requirements
- R1: After reset all counters are zero and the rotation pointer is at thread 0. With every thread eligible, the rotate policy and the halves shape, the first grant goes to thread 0 and the second to thread 1.
- R2: A thread's occupancy counter changes at each clock edge by its decode count minus its issue count minus its squash count, all applied in the same cycle. Its branch counter changes by branches entering minus branches done. Its miss counter changes by missStart minus missEnd.
- R3: A thread is eligible only when its readyMask bit is 1, its icacheStall bit is 0 and its blockLen is nonzero. When no thread is eligible, both grant valids are 0. An invalid grant drives id 0 and budget 0.
- R4: With policySel = 0 (rotate), every eligible thread has the same rank, so grants follow the pointer order. After a cycle with any grant, the pointer moves to one past the last granted thread: the second grant if there is one, otherwise the first. The pointer wraps from NUM_THREADS-1 to 0. With no grant the pointer holds.
- R5: With policySel = 1, the eligible thread with the smallest occupancy counter ranks first.
- R6: With policySel = 2, the eligible thread with the smallest unresolved-branch counter ranks first.
- R7: With policySel = 3, the eligible thread with the smallest outstanding-miss counter ranks first.
- R8: Among threads of equal rank, the one nearest at or after the pointer, in increasing thread order with wrap, wins. The second grant is the best-ranked eligible thread other than the first.
- R9: Budgets depend on shapeSel.
  - shapeSel = 0: one grant only, with budget min(blockLen, FETCH_WIDTH).
  - shapeSel = 1: each grant has budget min(blockLen, FETCH_WIDTH/2).
  - shapeSel = 2 or 3: the first grant has budget min(blockLen, FETCH_WIDTH). The second has budget min(blockLen, FETCH_WIDTH minus the first budget), and it is valid only if that is nonzero.
- R10: When exactly one thread is eligible, only a single grant is issued. When two grants are issued, their thread ids differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| policySel | input | 2 | 0 rotate, 1 occupancy, 2 branches, 3 misses |
| shapeSel | input | 2 | 0 single full width, 1 two halves, 2/3 two sharing full width |
| readyMask | input | NUM_THREADS | Thread may fetch |
| icacheStall | input | NUM_THREADS | Thread waits on an instruction-cache miss |
| blockLen | input | NUM_THREADS x LEN_W | Instructions available in each thread's next fetch block |
| decodeCnt | input | NUM_THREADS x LEN_W | Instructions entering decode this cycle |
| issueCnt | input | NUM_THREADS x LEN_W | Instructions leaving the queue this cycle |
| squashCnt | input | NUM_THREADS x OCC_W | Instructions removed by a flush this cycle |
| branchEnter | input | NUM_THREADS x LEN_W | Branches entering decode this cycle |
| branchDone | input | NUM_THREADS x LEN_W | Branches resolved or squashed this cycle |
| missStart | input | NUM_THREADS | A data-cache miss begins |
| missEnd | input | NUM_THREADS | A data-cache miss completes |
| grant0Valid | output | 1 | First grant present |
| grant0Id | output | TID_W | First granted thread |
| grant0Budget | output | LEN_W | Instructions the first thread may fetch |
| grant1Valid | output | 1 | Second grant present |
| grant1Id | output | TID_W | Second granted thread |
| grant1Budget | output | LEN_W | Instructions the second thread may fetch |

## Verification
Several properties are checked on every cycle:
- the first grant always names an eligible thread, and no grant appears when none is eligible;
- no eligible thread holds a smaller rank key than the first grant, and the second grant ranks strictly behind the first by key and then by pointer distance;
- the two ids differ, a shared-width pair never exceeds the fetch width, and a first grant never has a zero budget;
- counters stay within their bounds.

Only the bench's scenarios can show that counter arithmetic with simultaneous increments and decrements moves the ranking correctly, that the pointer lands one past the last grant and wraps, and that exact budgets follow each shape. It checks these against a model across many random event streams, and against directed cases with nothing, one thread or equal keys eligible.

// File: rtl/fetch_sel_pkg.sv
package fetch_sel_pkg;

  localparam int unsigned SEL_ID_W = 8;

  typedef enum logic [1:0] {
    POL_ROTATE    = 2'd0,
    POL_OCCUPANCY = 2'd1,
    POL_BRANCH    = 2'd2,
    POL_MISS      = 2'd3
  } fetchPolicy_e;

  typedef enum logic [1:0] {
    SHAPE_SOLO    = 2'd0,
    SHAPE_HALVES  = 2'd1,
    SHAPE_SHARED  = 2'd2,
    SHAPE_SHARED2 = 2'd3
  } grantShape_e;

  typedef struct packed {
    logic                firstValid;
    logic [SEL_ID_W-1:0] firstId;
    logic                secondValid;
    logic [SEL_ID_W-1:0] secondId;
  } pickStrobe_t;

endpackage

// File: rtl/fetch_sel_datapath.sv
module fetch_sel_datapath
  import fetch_sel_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned FETCH_WIDTH = 8,
  parameter int unsigned MAX_OCC     = 64,
  parameter int unsigned MAX_BRANCH  = 16,
  parameter int unsigned MAX_MISS    = 8,
  localparam int unsigned TID_W  = $clog2(NUM_THREADS),
  localparam int unsigned LEN_W  = $clog2(FETCH_WIDTH + 1),
  localparam int unsigned OCC_W  = $clog2(MAX_OCC + 1),
  localparam int unsigned BR_W   = $clog2(MAX_BRANCH + 1),
  localparam int unsigned MISS_W = $clog2(MAX_MISS + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [1:0]                        shapeSel,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0] blockLen,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0] decodeCnt,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0] issueCnt,
  input  logic [NUM_THREADS-1:0][OCC_W-1:0] squashCnt,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0] branchEnter,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0] branchDone,
  input  logic [NUM_THREADS-1:0]            missStart,
  input  logic [NUM_THREADS-1:0]            missEnd,
  input  pickStrobe_t                       picks,
  output logic [NUM_THREADS-1:0][OCC_W-1:0] occCnt,
  output logic [NUM_THREADS-1:0][BR_W-1:0]  brCnt,
  output logic [NUM_THREADS-1:0][MISS_W-1:0] missCnt,
  output logic                              grant0Valid,
  output logic [TID_W-1:0]                  grant0Id,
  output logic [LEN_W-1:0]                  grant0Budget,
  output logic                              grant1Valid,
  output logic [TID_W-1:0]                  grant1Id,
  output logic [LEN_W-1:0]                  grant1Budget
);

  localparam int unsigned OCC_SUM_W = OCC_W + 2;
  localparam int unsigned BR_SUM_W  = BR_W + 2;
  localparam int unsigned MISS_SUM_W = MISS_W + 1;
  localparam logic [LEN_W-1:0] FULL_CAP = LEN_W'(FETCH_WIDTH);
  localparam logic [LEN_W-1:0] HALF_CAP = LEN_W'(FETCH_WIDTH / 2);

  logic [NUM_THREADS-1:0][OCC_W-1:0]  occNext;
  logic [NUM_THREADS-1:0][BR_W-1:0]   brNext;
  logic [NUM_THREADS-1:0][MISS_W-1:0] missNext;

  // Per-thread counter arithmetic; all deltas land in the same cycle.
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      logic [OCC_SUM_W-1:0]  occSum;
      logic [BR_SUM_W-1:0]   brSum;
      logic [MISS_SUM_W-1:0] missSum;
      occSum = OCC_SUM_W'(occCnt[t]) + OCC_SUM_W'(decodeCnt[t])
             - OCC_SUM_W'(issueCnt[t]) - OCC_SUM_W'(squashCnt[t]);
      brSum  = BR_SUM_W'(brCnt[t]) + BR_SUM_W'(branchEnter[t])
             - BR_SUM_W'(branchDone[t]);
      missSum = MISS_SUM_W'(missCnt[t]) + MISS_SUM_W'(missStart[t])
              - MISS_SUM_W'(missEnd[t]);
      occNext[t]  = occSum[OCC_W-1:0];
      brNext[t]   = brSum[BR_W-1:0];
      missNext[t] = missSum[MISS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occCnt  <= '0;
      brCnt   <= '0;
      missCnt <= '0;
    end else begin
      occCnt  <= occNext;
      brCnt   <= brNext;
      missCnt <= missNext;
    end
  end

  function automatic logic [LEN_W-1:0] lenMin(input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // Budget shaping.
  logic [TID_W-1:0] id0, id1;
  logic [LEN_W-1:0] cap, room, budget0, budget1Raw;
  logic             shared;

  always_comb begin
    id0        = picks.firstId[TID_W-1:0];
    id1        = picks.secondId[TID_W-1:0];
    shared     = shapeSel[1];
    cap        = (shapeSel == SHAPE_HALVES) ? HALF_CAP : FULL_CAP;
    budget0    = picks.firstValid ? lenMin(blockLen[id0], cap) : '0;
    room       = shared ? (FULL_CAP - budget0) : cap;
    budget1Raw = lenMin(blockLen[id1], room);

    grant0Valid  = picks.firstValid;
    grant0Id     = picks.firstValid ? id0 : '0;
    grant0Budget = budget0;
    grant1Valid  = picks.secondValid && (shapeSel != SHAPE_SOLO) && (budget1Raw != '0);
    grant1Id     = grant1Valid ? id1 : '0;
    grant1Budget = grant1Valid ? budget1Raw : '0;
  end

  // R2: counters stay inside their bounds.
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_bound
    a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rstN)
      (occCnt[t] <= OCC_W'(MAX_OCC)) && (brCnt[t] <= BR_W'(MAX_BRANCH))
      && (missCnt[t] <= MISS_W'(MAX_MISS)));
  end

  a_r9_shared_cap: assert property (@(posedge clk) disable iff (!rstN)
    shared |-> ((LEN_W+1)'(grant0Budget) + (LEN_W+1)'(grant1Budget)) <= (LEN_W+1)'(FETCH_WIDTH));

  a_r9_first_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    grant0Valid |-> (grant0Budget != '0));

  a_r9_solo_single: assert property (@(posedge clk) disable iff (!rstN)
    (shapeSel == SHAPE_SOLO) |-> !grant1Valid);

endmodule

// File: rtl/fetch_sel_control.sv
module fetch_sel_control
  import fetch_sel_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned FETCH_WIDTH = 8,
  parameter int unsigned MAX_OCC     = 64,
  parameter int unsigned MAX_BRANCH  = 16,
  parameter int unsigned MAX_MISS    = 8,
  localparam int unsigned TID_W  = $clog2(NUM_THREADS),
  localparam int unsigned LEN_W  = $clog2(FETCH_WIDTH + 1),
  localparam int unsigned OCC_W  = $clog2(MAX_OCC + 1),
  localparam int unsigned BR_W   = $clog2(MAX_BRANCH + 1),
  localparam int unsigned MISS_W = $clog2(MAX_MISS + 1)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [1:0]                         policySel,
  input  logic [NUM_THREADS-1:0]             readyMask,
  input  logic [NUM_THREADS-1:0]             icacheStall,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0]  blockLen,
  input  logic [NUM_THREADS-1:0][OCC_W-1:0]  occCnt,
  input  logic [NUM_THREADS-1:0][BR_W-1:0]   brCnt,
  input  logic [NUM_THREADS-1:0][MISS_W-1:0] missCnt,
  input  logic                               secondGranted,
  output pickStrobe_t                        picks
);

  localparam int unsigned KW0   = (OCC_W > BR_W) ? OCC_W : BR_W;
  localparam int unsigned KEY_W = (KW0 > MISS_W) ? KW0 : MISS_W;
  localparam int unsigned DIST_W = TID_W + 1;

  logic [NUM_THREADS-1:0]              eligible;
  logic [NUM_THREADS-1:0][KEY_W-1:0]   keys;
  logic [NUM_THREADS-1:0][DIST_W-1:0]  dists;
  logic [TID_W-1:0]                    ptr;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_rank
    assign eligible[t] = readyMask[t] & ~icacheStall[t] & (blockLen[t] != '0);

    always_comb begin
      unique case (fetchPolicy_e'(policySel))
        POL_OCCUPANCY: keys[t] = KEY_W'(occCnt[t]);
        POL_BRANCH:    keys[t] = KEY_W'(brCnt[t]);
        POL_MISS:      keys[t] = KEY_W'(missCnt[t]);
        default:       keys[t] = '0;
      endcase
      if (TID_W'(t) >= ptr) dists[t] = DIST_W'(t) - DIST_W'(ptr);
      else                  dists[t] = DIST_W'(t) + DIST_W'(NUM_THREADS) - DIST_W'(ptr);
    end
  end

  // Returns {found, id} of the lowest {key, distance} in mask.
  function automatic logic [TID_W:0] pickBest(
      input logic [NUM_THREADS-1:0]             mask,
      input logic [NUM_THREADS-1:0][KEY_W-1:0]  k,
      input logic [NUM_THREADS-1:0][DIST_W-1:0] d);
    logic             found;
    logic [TID_W-1:0] best;
    logic [KEY_W-1:0] bestKey;
    logic [DIST_W-1:0] bestDist;
    found = 1'b0; best = '0; bestKey = '0; bestDist = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (mask[i] && (!found || (k[i] < bestKey)
                      || ((k[i] == bestKey) && (d[i] < bestDist)))) begin
        found = 1'b1; best = TID_W'(i); bestKey = k[i]; bestDist = d[i];
      end
    end
    return {found, best};
  endfunction

  logic [TID_W:0]         first, second;
  logic [NUM_THREADS-1:0] restMask;

  always_comb begin
    first    = pickBest(eligible, keys, dists);
    restMask = eligible & ~(NUM_THREADS'(1) << first[TID_W-1:0]);
    second   = pickBest(first[TID_W] ? restMask : '0, keys, dists);
    picks.firstValid  = first[TID_W];
    picks.firstId     = SEL_ID_W'(first[TID_W-1:0]);
    picks.secondValid = second[TID_W];
    picks.secondId    = SEL_ID_W'(second[TID_W-1:0]);
  end

  // Pointer moves one past the last thread granted.
  logic [TID_W-1:0] lastId, nextPtr;
  always_comb begin
    lastId  = secondGranted ? second[TID_W-1:0] : first[TID_W-1:0];
    nextPtr = (lastId == TID_W'(NUM_THREADS - 1)) ? '0 : lastId + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ptr <= '0;
    else if (picks.firstValid) ptr <= nextPtr;
  end

  // Checker helpers.
  logic [TID_W-1:0] chkId0, chkId1;
  logic             lowerSeen;
  always_comb begin
    chkId0    = picks.firstId[TID_W-1:0];
    chkId1    = picks.secondId[TID_W-1:0];
    lowerSeen = 1'b0;
    for (int i = 0; i < NUM_THREADS; i++)
      if (eligible[i] && (keys[i] < keys[chkId0])) lowerSeen = 1'b1;
  end

  a_r3_first_eligible: assert property (@(posedge clk) disable iff (!rstN)
    picks.firstValid |-> eligible[chkId0]);

  a_r3_idle_when_none: assert property (@(posedge clk) disable iff (!rstN)
    (eligible == '0) |-> (!picks.firstValid && !picks.secondValid));

  a_r5_first_minimal: assert property (@(posedge clk) disable iff (!rstN)
    picks.firstValid |-> !lowerSeen);

  a_r8_second_behind: assert property (@(posedge clk) disable iff (!rstN)
    picks.secondValid |-> ((keys[chkId0] < keys[chkId1])
      || ((keys[chkId0] == keys[chkId1]) && (dists[chkId0] < dists[chkId1]))));

  a_r10_distinct: assert property (@(posedge clk) disable iff (!rstN)
    picks.secondValid |-> (picks.firstValid && (chkId0 != chkId1) && eligible[chkId1]));

  a_r10_single_when_one: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(eligible) == 1) |-> !picks.secondValid);

endmodule

// File: rtl/fetch_selector.sv
module fetch_selector
  import fetch_sel_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned FETCH_WIDTH = 8,
  parameter int unsigned MAX_OCC     = 64,
  parameter int unsigned MAX_BRANCH  = 16,
  parameter int unsigned MAX_MISS    = 8,
  localparam int unsigned TID_W  = $clog2(NUM_THREADS),
  localparam int unsigned LEN_W  = $clog2(FETCH_WIDTH + 1),
  localparam int unsigned OCC_W  = $clog2(MAX_OCC + 1),
  localparam int unsigned BR_W   = $clog2(MAX_BRANCH + 1),
  localparam int unsigned MISS_W = $clog2(MAX_MISS + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [1:0]                        policySel,
  input  logic [1:0]                        shapeSel,
  input  logic [NUM_THREADS-1:0]            readyMask,
  input  logic [NUM_THREADS-1:0]            icacheStall,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0] blockLen,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0] decodeCnt,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0] issueCnt,
  input  logic [NUM_THREADS-1:0][OCC_W-1:0] squashCnt,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0] branchEnter,
  input  logic [NUM_THREADS-1:0][LEN_W-1:0] branchDone,
  input  logic [NUM_THREADS-1:0]            missStart,
  input  logic [NUM_THREADS-1:0]            missEnd,
  output logic                              grant0Valid,
  output logic [TID_W-1:0]                  grant0Id,
  output logic [LEN_W-1:0]                  grant0Budget,
  output logic                              grant1Valid,
  output logic [TID_W-1:0]                  grant1Id,
  output logic [LEN_W-1:0]                  grant1Budget
);

  pickStrobe_t                        picks;
  logic [NUM_THREADS-1:0][OCC_W-1:0]  occCnt;
  logic [NUM_THREADS-1:0][BR_W-1:0]   brCnt;
  logic [NUM_THREADS-1:0][MISS_W-1:0] missCnt;

  fetch_sel_control #(
    .NUM_THREADS(NUM_THREADS), .FETCH_WIDTH(FETCH_WIDTH), .MAX_OCC(MAX_OCC),
    .MAX_BRANCH(MAX_BRANCH), .MAX_MISS(MAX_MISS)
  ) i_control (
    .clk(clk), .rstN(rstN), .policySel(policySel), .readyMask(readyMask),
    .icacheStall(icacheStall), .blockLen(blockLen), .occCnt(occCnt),
    .brCnt(brCnt), .missCnt(missCnt), .secondGranted(grant1Valid), .picks(picks)
  );

  fetch_sel_datapath #(
    .NUM_THREADS(NUM_THREADS), .FETCH_WIDTH(FETCH_WIDTH), .MAX_OCC(MAX_OCC),
    .MAX_BRANCH(MAX_BRANCH), .MAX_MISS(MAX_MISS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .shapeSel(shapeSel), .blockLen(blockLen),
    .decodeCnt(decodeCnt), .issueCnt(issueCnt), .squashCnt(squashCnt),
    .branchEnter(branchEnter), .branchDone(branchDone), .missStart(missStart),
    .missEnd(missEnd), .picks(picks), .occCnt(occCnt), .brCnt(brCnt),
    .missCnt(missCnt), .grant0Valid(grant0Valid), .grant0Id(grant0Id),
    .grant0Budget(grant0Budget), .grant1Valid(grant1Valid), .grant1Id(grant1Id),
    .grant1Budget(grant1Budget)
  );

endmodule

// File: tb/test_fetch_selector.sv
module test_fetch_selector;

  localparam int NT = 8;
  localparam int FW = 8;
  localparam int MAX_OCC = 64;
  localparam int MAX_BR = 16;
  localparam int MAX_MISS = 8;
  localparam int TID_W = 3;
  localparam int LEN_W = 4;
  localparam int OCC_W = 7;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] policySel = '0;
  logic [1:0] shapeSel = '0;
  logic [NT-1:0] readyMask = '0;
  logic [NT-1:0] icacheStall = '0;
  logic [NT-1:0][LEN_W-1:0] blockLen = '0;
  logic [NT-1:0][LEN_W-1:0] decodeCnt = '0;
  logic [NT-1:0][LEN_W-1:0] issueCnt = '0;
  logic [NT-1:0][OCC_W-1:0] squashCnt = '0;
  logic [NT-1:0][LEN_W-1:0] branchEnter = '0;
  logic [NT-1:0][LEN_W-1:0] branchDone = '0;
  logic [NT-1:0] missStart = '0;
  logic [NT-1:0] missEnd = '0;
  logic grant0Valid, grant1Valid;
  logic [TID_W-1:0] grant0Id, grant1Id;
  logic [LEN_W-1:0] grant0Budget, grant1Budget;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_selector i_fetch_selector (
    .clk(clk), .rstN(rstN), .policySel(policySel), .shapeSel(shapeSel),
    .readyMask(readyMask), .icacheStall(icacheStall), .blockLen(blockLen),
    .decodeCnt(decodeCnt), .issueCnt(issueCnt), .squashCnt(squashCnt),
    .branchEnter(branchEnter), .branchDone(branchDone), .missStart(missStart),
    .missEnd(missEnd), .grant0Valid(grant0Valid), .grant0Id(grant0Id),
    .grant0Budget(grant0Budget), .grant1Valid(grant1Valid), .grant1Id(grant1Id),
    .grant1Budget(grant1Budget)
  );

  int checks = 0;
  int errors = 0;
  int occM[NT], brM[NT], missM[NT];
  int ptrM = 0;
  int e0v, e0id, e0b, e1v, e1id, e1b;
  bit done = 0;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int keyOf(int t);
    case (policySel)
      2'd1: return occM[t];
      2'd2: return brM[t];
      2'd3: return missM[t];
      default: return 0;
    endcase
  endfunction

  function automatic bit isElig(int t);
    return readyMask[t] && !icacheStall[t] && (blockLen[t] != 0);
  endfunction

  function automatic int bestOf(int exclude);
    int best = -1, bk = 0, bd = 0;
    for (int t = 0; t < NT; t++) begin
      int k = keyOf(t);
      int d = (t - ptrM + NT) % NT;
      if (isElig(t) && t != exclude &&
          (best < 0 || k < bk || (k == bk && d < bd))) begin
        best = t; bk = k; bd = d;
      end
    end
    return best;
  endfunction

  task automatic computeExpect();
    int f0, f1, cap, room, b1;
    f0 = bestOf(-1);
    f1 = (f0 >= 0) ? bestOf(f0) : -1;
    cap = (shapeSel == 2'd1) ? FW/2 : FW;
    e0v = (f0 >= 0); e0id = e0v ? f0 : 0;
    e0b = e0v ? imin(int'(blockLen[f0]), cap) : 0;
    room = shapeSel[1] ? (FW - e0b) : cap;
    b1 = (f1 >= 0) ? imin(int'(blockLen[f1]), room) : 0;
    e1v = (f1 >= 0) && (shapeSel != 2'd0) && (b1 > 0);
    e1id = e1v ? f1 : 0;
    e1b = e1v ? b1 : 0;
  endtask

  task automatic checkOne(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic applyModel();
    for (int t = 0; t < NT; t++) begin
      occM[t]  += int'(decodeCnt[t]) - int'(issueCnt[t]) - int'(squashCnt[t]);
      brM[t]   += int'(branchEnter[t]) - int'(branchDone[t]);
      missM[t] += int'(missStart[t]) - int'(missEnd[t]);
    end
    if (e0v) ptrM = ((e1v ? e1id : e0id) + 1) % NT;
  endtask

  // Inputs are set just after a falling edge; compare, then advance one clock.
  task automatic runCycle(string tag);
    #1;
    computeExpect();
    checkOne(tag, "grant0Valid", int'(grant0Valid), e0v);
    checkOne(tag, "grant0Id", int'(grant0Id), e0id);
    checkOne(tag, "grant0Budget", int'(grant0Budget), e0b);
    checkOne(tag, "grant1Valid", int'(grant1Valid), e1v);
    checkOne(tag, "grant1Id", int'(grant1Id), e1id);
    checkOne(tag, "grant1Budget", int'(grant1Budget), e1b);
    applyModel();
    @(negedge clk);
  endtask

  task automatic clearEvents();
    decodeCnt = '0; issueCnt = '0; squashCnt = '0;
    branchEnter = '0; branchDone = '0; missStart = '0; missEnd = '0;
  endtask

  task automatic allLen(int n);
    for (int t = 0; t < NT; t++) blockLen[t] = LEN_W'(n);
  endtask

  task automatic randomEvents();
    for (int t = 0; t < NT; t++) begin
      int iss, sq;
      decodeCnt[t] = LEN_W'($urandom_range(imin(FW, MAX_OCC - occM[t]), 0));
      iss = $urandom_range(imin(FW, occM[t]), 0);
      issueCnt[t] = LEN_W'(iss);
      sq = ($urandom_range(7, 0) == 0) ? $urandom_range(occM[t] - iss, 0) : 0;
      squashCnt[t] = OCC_W'(sq);
      branchEnter[t] = LEN_W'($urandom_range(imin(3, MAX_BR - brM[t]), 0));
      branchDone[t] = LEN_W'($urandom_range(imin(3, brM[t]), 0));
      missStart[t] = (missM[t] < MAX_MISS) && ($urandom_range(3, 0) == 0);
      missEnd[t] = (missM[t] > 0) && ($urandom_range(3, 0) == 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0C0D);
    for (int t = 0; t < NT; t++) begin occM[t] = 0; brM[t] = 0; missM[t] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, rotate policy, halves shape.
    policySel = 2'd0; shapeSel = 2'd1; readyMask = '1; allLen(8);
    runCycle("R1");
    // R4: rotation continues past the last grant, then wraps.
    runCycle("R4");
    runCycle("R4");
    shapeSel = 2'd0; runCycle("R4");
    runCycle("R4"); runCycle("R4");

    // R3: nothing ready, then stalled, then empty blocks.
    readyMask = '0; runCycle("R3");
    readyMask = '1; icacheStall = 8'hDF; shapeSel = 2'd2; runCycle("R10");
    blockLen[5] = 0; runCycle("R3");
    icacheStall = '0; allLen(8);

    // R9: shared width split.
    blockLen[ptrM] = 5; blockLen[(ptrM + 1) % NT] = 6; runCycle("R9");
    blockLen = '0; blockLen[2] = 8; blockLen[3] = 8; runCycle("R9");
    allLen(3); shapeSel = 2'd3; runCycle("R9");
    allLen(8);

    // R2/R5: occupancy with simultaneous in and out.
    policySel = 2'd1; shapeSel = 2'd1;
    decodeCnt[0] = 5; decodeCnt[1] = 3; decodeCnt[2] = 8; runCycle("R2");
    clearEvents();
    decodeCnt[0] = 1; issueCnt[0] = 2; squashCnt[0] = 1; decodeCnt[3] = 2; runCycle("R2");
    clearEvents();
    for (int t = 4; t < NT; t++) decodeCnt[t] = 6;
    runCycle("R5");
    clearEvents(); runCycle("R5");
    // R8: equal keys follow the pointer.
    for (int t = 0; t < NT; t++) squashCnt[t] = OCC_W'(occM[t]);
    runCycle("R8");
    clearEvents(); runCycle("R8"); runCycle("R8");

    // R6: branches; R7: misses.
    policySel = 2'd2;
    branchEnter[0] = 4; branchEnter[1] = 1; branchEnter[6] = 2; runCycle("R6");
    clearEvents(); runCycle("R6");
    branchDone[0] = 4; runCycle("R6");
    clearEvents(); runCycle("R6");
    policySel = 2'd3;
    missStart = 8'b0111_1110; runCycle("R7");
    clearEvents(); missEnd[3] = 1; missStart[3] = 1; runCycle("R7");
    clearEvents(); runCycle("R7");

    // Random phase across all policies and shapes.
    for (int blk = 0; blk < 24; blk++) begin
      policySel = 2'($urandom_range(3, 0));
      shapeSel = 2'($urandom_range(3, 0));
      for (int c = 0; c < 80; c++) begin
        readyMask = NT'($urandom());
        icacheStall = ($urandom_range(3, 0) == 0) ? NT'($urandom()) : '0;
        for (int t = 0; t < NT; t++) blockLen[t] = LEN_W'($urandom_range(FW, 0));
        randomEvents();
        case (policySel)
          2'd0: runCycle("R4");
          2'd1: runCycle("R5");
          2'd2: runCycle("R6");
          default: runCycle("R7");
        endcase
      end
    end
    clearEvents();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule